// File: doc/BRIEF.md
# Register Window Management Controller

This controller keeps the bookkeeping for a circular bank of `NWINDOWS` register windows. It holds the current window pointer and five pieces of window state: the count of windows free for a save, the count of windows that can be restored, the count of clean windows, the count of windows owned by another context, and a 6-bit handler-select register. The actual register file and the trap handlers are outside this block.

The pipeline sends one command per cycle: save, restore, return, or a load that sets all the state at once. Each accepted command has one of two results. Either it shifts the window pointer and adjusts the counters, or it reports a single trap. A trap carries a type code and a 3-bit handler selector, and it leaves all the state as it was. A return also checks that its target address is word aligned. An aligned return that succeeds produces a one-cycle redirect to that target.

With every accepted command the controller also reports two windows: the one that the command's source operands read, which is the old window, and the one that its result writes, which is the new window. The result of a shift can therefore be written into the window the command has just moved to.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the free-for-save count is NWINDOWS-2, the restorable count is 0, the clean count is NWINDOWS-1, the other-context count is 0 and the selector register is 0. No trap or redirect is reported, and both window outputs are 0.
- R2: Command code 3 is a load. It takes the free-for-save count from target bits [4:0], the restorable count from [9:5], the clean count from [14:10], the other-context count from [19:15], the selector register from [25:20] and the pointer from [26 +: clog2(NWINDOWS)]. A loaded pointer of NWINDOWS or more becomes 0. A load never traps.
- R3: A save (code 0) with no trap moves the pointer to (pointer+1) mod NWINDOWS. It subtracts one from the free-for-save count and adds one to the restorable count. All counters are 5 bits wide and wrap.
- R4: A save with a free-for-save count of 0 reports a spill trap. The trap type is 1 and the selector is register bits [2:0] when the other-context count is 0. Otherwise the type is 2 and the selector is bits [5:3].
- R5: A save with a nonzero free-for-save count whose clean count equals its restorable count reports a clean-window trap with type 5 and selector 0. The spill check has priority over this one.
- R6: A restore (code 1) with a restorable count of 0 reports a fill trap. The type is 3 with selector bits [2:0] when the other-context count is 0, and otherwise type 4 with selector bits [5:3].
- R7: A restore with no trap moves the pointer to (pointer-1+NWINDOWS) mod NWINDOWS. It adds one to the free-for-save count and subtracts one from the restorable count.
- R8: A return (code 2) whose target has bit 1 or bit 0 set reports an alignment trap with type 6 and selector 0. This check comes before the fill check.
- R9: An aligned return applies the fill check and the window step of a restore. When it succeeds, it raises the redirect output for one cycle with the target on the redirect address. A redirect never occurs together with a trap.
- R10: Each command reports at most one trap. When a command traps, the pointer and all the counters keep their values. The trap and redirect outputs are pulses that last one cycle.
- R11: Each accepted command sets the read window to the pointer before the command and the write window to the pointer after it. The two are equal when the command traps. Both hold their values while no command is accepted.
- R12: All results are registered and appear after the clock edge that accepts the command. With the command strobe low, nothing changes, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code: 0 save, 1 restore, 2 return, 3 load |
| cmd_target_i | input | ADDR_W | Return target, or the packed fields of a load |
| cwp_o | output | clog2(NWINDOWS) | Current window pointer |
| rd_win_o | output | clog2(NWINDOWS) | Window the last command read |
| wr_win_o | output | clog2(NWINDOWS) | Window the last command writes |
| trap_valid_o | output | 1 | Trap pulse |
| trap_type_o | output | 3 | Trap type code |
| trap_vec_o | output | 3 | Handler selector |
| redir_valid_o | output | 1 | Redirect pulse after a successful return |
| redir_pc_o | output | ADDR_W | Redirect target |

## Verification
The bench works through the priority corners:
- A misaligned return while the restorable count is 0. A design that checked fill first would report type 3 or 4 instead of 6.
- A save that meets both the spill and the clean-window conditions at once, which must report the spill.
- The other-context switch. Swapped selector fields would show up as a wrong selector.

It also steps the pointer across the wrap in both directions, which a non-modular step would get wrong. After every trap it checks that the pointer and the window outputs did not move. Idle cycles with a live-looking opcode confirm that the strobe gates every update.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  localparam int CNT_W = 5;
  localparam int SEL_W = 6;

  localparam int LD_FREE_LSB  = 0;
  localparam int LD_REST_LSB  = 5;
  localparam int LD_CLEAN_LSB = 10;
  localparam int LD_OTHER_LSB = 15;
  localparam int LD_SEL_LSB   = 20;
  localparam int LD_PTR_LSB   = 26;

  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_RETURN  = 2'd2,
    OP_LOAD    = 2'd3
  } rwin_op_e;

  typedef enum logic [2:0] {
    TRAP_NONE    = 3'd0,
    TRAP_SPILL_N = 3'd1,
    TRAP_SPILL_O = 3'd2,
    TRAP_FILL_N  = 3'd3,
    TRAP_FILL_O  = 3'd4,
    TRAP_CLEAN   = 3'd5,
    TRAP_ALIGN   = 3'd6
  } rwin_trap_e;

  typedef struct packed {
    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] rest_cnt;
    logic [CNT_W-1:0] clean_cnt;
    logic [CNT_W-1:0] other_cnt;
    logic [SEL_W-1:0] sel_reg;
  } rwin_cnt_t;

endpackage

// File: rtl/rwin_rst_sync.sv
module rwin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/rwin_ptr_step.sv
module rwin_ptr_step #(
  parameter int NWIN = 8,
  localparam int PW = $clog2(NWIN)
) (
  input  logic [PW-1:0] ptr_i,
  output logic [PW-1:0] inc_o,
  output logic [PW-1:0] dec_o
);

  localparam logic [PW-1:0] LAST = PW'(NWIN - 1);

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      // Natural binary wrap is already modulo NWIN.
      assign inc_o = ptr_i + 1'b1;
      assign dec_o = ptr_i - 1'b1;
    end else begin : g_any
      assign inc_o = (ptr_i == LAST) ? '0 : ptr_i + 1'b1;
      assign dec_o = (ptr_i == '0) ? LAST : ptr_i - 1'b1;
    end
  endgenerate

endmodule

// File: rtl/rwin_trap_eval.sv
module rwin_trap_eval
  import rwin_pkg::*;
(
  input  rwin_op_e   op_i,
  input  logic [1:0] tgt_lo_i,
  input  rwin_cnt_t  cnt_i,
  output rwin_trap_e trap_o,
  output logic [2:0] vec_o
);

  logic       other_side;
  logic [2:0] side_sel;

  assign other_side = |cnt_i.other_cnt;
  assign side_sel   = other_side ? cnt_i.sel_reg[5:3] : cnt_i.sel_reg[2:0];

  always_comb begin
    trap_o = TRAP_NONE;
    vec_o  = 3'd0;
    unique case (op_i)
      OP_SAVE: begin
        if (cnt_i.free_cnt == '0) begin
          trap_o = other_side ? TRAP_SPILL_O : TRAP_SPILL_N;
          vec_o  = side_sel;
        end else if (cnt_i.clean_cnt == cnt_i.rest_cnt) begin
          trap_o = TRAP_CLEAN;
        end
      end
      OP_RESTORE: begin
        if (cnt_i.rest_cnt == '0) begin
          trap_o = other_side ? TRAP_FILL_O : TRAP_FILL_N;
          vec_o  = side_sel;
        end
      end
      OP_RETURN: begin
        // Alignment is judged before any window check.
        if (tgt_lo_i != 2'b00) begin
          trap_o = TRAP_ALIGN;
        end else if (cnt_i.rest_cnt == '0) begin
          trap_o = other_side ? TRAP_FILL_O : TRAP_FILL_N;
          vec_o  = side_sel;
        end
      end
      default: trap_o = TRAP_NONE;
    endcase
  end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int ADDR_W   = 32,
  localparam int PW      = $clog2(NWINDOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_target_i,
  output logic [PW-1:0]     cwp_o,
  output logic [PW-1:0]     rd_win_o,
  output logic [PW-1:0]     wr_win_o,
  output logic              trap_valid_o,
  output logic [2:0]        trap_type_o,
  output logic [2:0]        trap_vec_o,
  output logic              redir_valid_o,
  output logic [ADDR_W-1:0] redir_pc_o
);

  localparam logic [CNT_W-1:0] RST_FREE  = CNT_W'(NWINDOWS - 2);
  localparam logic [CNT_W-1:0] RST_CLEAN = CNT_W'(NWINDOWS - 1);

  logic rst_sync_n;

  rwin_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rwin_op_e  op;
  rwin_cnt_t cnt_q, cnt_d;
  logic [PW-1:0] cwp_q, cwp_d, cwp_inc, cwp_dec, load_ptr;
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  rwin_trap_e trap_now;
  logic [2:0] vec_now;
  logic       tv_q, tv_d, rv_q, rv_d;
  logic [2:0] tt_q, tt_d, tvec_q, tvec_d;
  logic [ADDR_W-1:0] rpc_q, rpc_d;

  assign op = rwin_op_e'(cmd_op_i);

  rwin_ptr_step #(.NWIN(NWINDOWS)) u_step (
    .ptr_i (cwp_q),
    .inc_o (cwp_inc),
    .dec_o (cwp_dec)
  );

  rwin_trap_eval u_eval (
    .op_i     (op),
    .tgt_lo_i (cmd_target_i[1:0]),
    .cnt_i    (cnt_q),
    .trap_o   (trap_now),
    .vec_o    (vec_now)
  );

  // Loaded pointer values outside the ring fall back to window 0.
  always_comb begin
    load_ptr = cmd_target_i[LD_PTR_LSB +: PW];
    if (32'(load_ptr) >= NWINDOWS) load_ptr = '0;
  end

  // Next-state
  always_comb begin
    cnt_d  = cnt_q;
    cwp_d  = cwp_q;
    rd_d   = rd_q;
    wr_d   = wr_q;
    tv_d   = 1'b0;
    tt_d   = 3'd0;
    tvec_d = 3'd0;
    rv_d   = 1'b0;
    rpc_d  = rpc_q;
    if (cmd_valid_i) begin
      rd_d = cwp_q;
      wr_d = cwp_q;
      if (trap_now != TRAP_NONE) begin
        tv_d   = 1'b1;
        tt_d   = trap_now;
        tvec_d = vec_now;
      end else begin
        unique case (op)
          OP_SAVE: begin
            cwp_d          = cwp_inc;
            cnt_d.free_cnt = cnt_q.free_cnt - 1'b1;
            cnt_d.rest_cnt = cnt_q.rest_cnt + 1'b1;
          end
          OP_RESTORE, OP_RETURN: begin
            cwp_d          = cwp_dec;
            cnt_d.free_cnt = cnt_q.free_cnt + 1'b1;
            cnt_d.rest_cnt = cnt_q.rest_cnt - 1'b1;
            if (op == OP_RETURN) begin
              rv_d  = 1'b1;
              rpc_d = cmd_target_i;
            end
          end
          default: begin
            cwp_d           = load_ptr;
            cnt_d.free_cnt  = cmd_target_i[LD_FREE_LSB  +: CNT_W];
            cnt_d.rest_cnt  = cmd_target_i[LD_REST_LSB  +: CNT_W];
            cnt_d.clean_cnt = cmd_target_i[LD_CLEAN_LSB +: CNT_W];
            cnt_d.other_cnt = cmd_target_i[LD_OTHER_LSB +: CNT_W];
            cnt_d.sel_reg   = cmd_target_i[LD_SEL_LSB   +: SEL_W];
          end
        endcase
        wr_d = cwp_d;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q.free_cnt  <= RST_FREE;
      cnt_q.rest_cnt  <= '0;
      cnt_q.clean_cnt <= RST_CLEAN;
      cnt_q.other_cnt <= '0;
      cnt_q.sel_reg   <= '0;
      cwp_q  <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      tv_q   <= 1'b0;
      tt_q   <= 3'd0;
      tvec_q <= 3'd0;
      rv_q   <= 1'b0;
      rpc_q  <= '0;
    end else begin
      if (cmd_valid_i) begin
        cnt_q <= cnt_d;
        cwp_q <= cwp_d;
        rd_q  <= rd_d;
        wr_q  <= wr_d;
      end
      if (rv_d) rpc_q <= rpc_d;
      tv_q   <= tv_d;
      tt_q   <= tt_d;
      tvec_q <= tvec_d;
      rv_q   <= rv_d;
    end
  end

  assign cwp_o         = cwp_q;
  assign rd_win_o      = rd_q;
  assign wr_win_o      = wr_q;
  assign trap_valid_o  = tv_q;
  assign trap_type_o   = tt_q;
  assign trap_vec_o    = tvec_q;
  assign redir_valid_o = rv_q;
  assign redir_pc_o    = rpc_q;

  // Assertions
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    32'(cwp_o) < NWINDOWS);

  p_save_step_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && op == OP_SAVE && cnt_q.free_cnt != '0 &&
     cnt_q.clean_cnt != cnt_q.rest_cnt) |=> (cwp_o == $past(cwp_inc)));

  p_spill_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && op == OP_SAVE && cnt_q.free_cnt == '0) |=>
    (trap_valid_o && (trap_type_o == TRAP_SPILL_N || trap_type_o == TRAP_SPILL_O)));

  p_restore_cnt_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && op == OP_RESTORE && cnt_q.rest_cnt != '0) |=>
    (cnt_q.free_cnt == CNT_W'($past(cnt_q.free_cnt) + 1'b1)));

  p_align_first_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && op == OP_RETURN && cmd_target_i[1:0] != 2'b00) |=>
    (trap_valid_o && trap_type_o == TRAP_ALIGN));

  p_redir_clean_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redir_valid_o |-> (!trap_valid_o && redir_pc_o[1:0] == 2'b00));

  p_trap_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_valid_o |-> $stable(cwp_o));

  p_trap_win_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_valid_o |-> (rd_win_o == wr_win_o));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_valid_i |=> (!trap_valid_o && !redir_valid_o && $stable(cwp_o)));

endmodule

// File: tb/rwin_ctrl_tb_top.sv
`timescale 1ns/1ps
module rwin_ctrl_tb_top;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int PW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_target;
  logic [PW-1:0] cwp, rd_win, wr_win;
  logic          trap_valid, redir_valid;
  logic [2:0]    trap_type, trap_vec;
  logic [AW-1:0] redir_pc;

  always #4 clk = ~clk;

  rwin_ctrl #(.NWINDOWS(N), .ADDR_W(AW)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid_i (cmd_valid), .cmd_op_i (cmd_op), .cmd_target_i (cmd_target),
    .cwp_o (cwp), .rd_win_o (rd_win), .wr_win_o (wr_win),
    .trap_valid_o (trap_valid), .trap_type_o (trap_type), .trap_vec_o (trap_vec),
    .redir_valid_o (redir_valid), .redir_pc_o (redir_pc)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Bench model state
  int m_cwp, m_free, m_rest, m_clean, m_other, m_sel;
  int e_tv, e_tt, e_vec, e_rv, e_rd, e_wr;
  logic [AW-1:0] e_pc;
  string tag;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pack_load(int fr, int re, int cl, int ot, int sl, int p);
    return AW'(fr & 31) | (AW'(re & 31) << 5) | (AW'(cl & 31) << 10) |
           (AW'(ot & 31) << 15) | (AW'(sl & 63) << 20) | (AW'(p) << 26);
  endfunction

  task automatic model(input logic v, input int op, input logic [AW-1:0] t);
    int side_vec;
    side_vec = (m_other != 0) ? ((m_sel >> 3) & 7) : (m_sel & 7);
    e_tv = 0; e_tt = 0; e_vec = 0; e_rv = 0;
    if (!v) begin tag = "R12"; return; end
    e_rd = m_cwp;
    case (op)
      0: begin
        if (m_free == 0) begin
          e_tv = 1; e_tt = (m_other != 0) ? 2 : 1; e_vec = side_vec; tag = "R4";
        end else if (m_clean == m_rest) begin
          e_tv = 1; e_tt = 5; tag = "R5";
        end else begin
          m_cwp = (m_cwp + 1) % N; m_free = (m_free - 1) & 31;
          m_rest = (m_rest + 1) & 31; tag = "R3";
        end
      end
      1, 2: begin
        if (op == 2 && t[1:0] != 2'b00) begin
          e_tv = 1; e_tt = 6; tag = "R8";
        end else if (m_rest == 0) begin
          e_tv = 1; e_tt = (m_other != 0) ? 4 : 3; e_vec = side_vec;
          tag = (op == 2) ? "R9" : "R6";
        end else begin
          m_cwp = (m_cwp + N - 1) % N; m_free = (m_free + 1) & 31;
          m_rest = (m_rest - 1) & 31;
          if (op == 2) begin e_rv = 1; e_pc = t; tag = "R9"; end
          else tag = "R7";
        end
      end
      default: begin
        m_free = int'(t[4:0]); m_rest = int'(t[9:5]); m_clean = int'(t[14:10]);
        m_other = int'(t[19:15]); m_sel = int'(t[25:20]);
        m_cwp = int'(t[26 +: PW]); tag = "R2";
      end
    endcase
    e_wr = m_cwp;
  endtask

  task automatic do_cmd(input logic v, input int op, input logic [AW-1:0] t);
    string st;
    cmd_valid = v; cmd_op = 2'(op); cmd_target = t;
    model(v, op, t);
    @(posedge clk); @(negedge clk);
    st = (e_tv != 0) ? "R10" : tag;
    chk(tag, "trap_valid", int'(trap_valid), e_tv);
    if (e_tv != 0) begin
      chk(tag, "trap_type", int'(trap_type), e_tt);
      chk(tag, "trap_vec", int'(trap_vec), e_vec);
    end
    chk(e_rv != 0 ? "R9" : st, "redir_valid", int'(redir_valid), e_rv);
    if (e_rv != 0) chk("R9", "redir_pc", int'(redir_pc), int'(e_pc));
    chk(st, "cwp", int'(cwp), m_cwp);
    chk("R11", "rd_win", int'(rd_win), e_rd);
    chk("R11", "wr_win", int'(wr_win), e_wr);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_target = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cwp = 0; m_free = N - 2; m_rest = 0; m_clean = N - 1; m_other = 0; m_sel = 0;
    e_rd = 0; e_wr = 0; e_pc = '0;

    // R1 reset state
    chk("R1", "cwp", int'(cwp), 0);
    chk("R1", "trap_valid", int'(trap_valid), 0);
    chk("R1", "redir_valid", int'(redir_valid), 0);
    chk("R1", "rd_win", int'(rd_win), 0);
    chk("R1", "wr_win", int'(wr_win), 0);

    // R1/R6: restorable count is 0 after reset -> fill, normal side
    do_cmd(1'b1, 1, '0);
    // R8: misaligned return has priority over an empty restorable count
    do_cmd(1'b1, 2, 32'h0000_1003);
    // R3/R4: free count N-2 after reset: N-2 saves then a spill
    for (int i = 0; i < N - 1; i++) do_cmd(1'b1, 0, '0);
    // R10: trap pulse is gone on the next idle cycle (R12 idle)
    do_cmd(1'b0, 0, '0);
    // R4: spill on the other side, selector from high field
    do_cmd(1'b1, 3, pack_load(0, 2, 5, 1, 6'b101_011, 3));
    do_cmd(1'b1, 0, '0);
    do_cmd(1'b1, 3, pack_load(0, 2, 2, 0, 6'b101_011, 3));
    do_cmd(1'b1, 0, '0);   // spill normal with clean==rest too: spill first (R5 priority)
    // R5: clean-window trap
    do_cmd(1'b1, 3, pack_load(3, 2, 2, 0, 6'b010_110, 4));
    do_cmd(1'b1, 0, '0);
    // R6: fill on the other side
    do_cmd(1'b1, 3, pack_load(4, 0, 6, 2, 6'b110_001, 1));
    do_cmd(1'b1, 1, '0);
    // R3 wrap upward, R7 wrap downward
    do_cmd(1'b1, 3, pack_load(3, 0, 5, 0, 0, N - 1));
    do_cmd(1'b1, 0, '0);
    do_cmd(1'b1, 1, '0);
    do_cmd(1'b1, 1, '0);
    // R9: aligned return succeeds and redirects
    do_cmd(1'b1, 3, pack_load(2, 3, 6, 0, 0, 5));
    do_cmd(1'b1, 2, 32'hCAFE_0A40);
    do_cmd(1'b0, 2, 32'h0000_0010);
    // R12: strobe low with every opcode
    for (int k = 0; k < 4; k++) do_cmd(1'b0, k, 32'hFFFF_FFFF);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r, op;
      logic [AW-1:0] t;
      r = int'($urandom_range(0, 15));
      if (r == 0) begin
        op = 3;
        t = pack_load(int'($urandom_range(0, N - 1)), int'($urandom_range(0, N - 1)),
                      int'($urandom_range(0, N - 1)), int'($urandom_range(0, 1)) * int'($urandom_range(1, 3)),
                      int'($urandom_range(0, 63)), int'($urandom_range(0, N - 1)));
      end else begin
        op = int'($urandom_range(0, 2));
        t = $urandom();
        if ($urandom_range(0, 3) != 0) t[1:0] = 2'b00;
      end
      do_cmd(($urandom_range(0, 7) != 0), op, t);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule